// File: doc/BRIEF.md
# Two-Level Prioritized Interrupt Controller

This block collects up to fifteen interrupt request lines (numbered 1 to 15) and distributes them to a configurable number of processors. A rising edge on a request line is recorded in one of two places. If the line is not marked for broadcast, it goes into a pending vector shared by all processors. If it is marked for broadcast, it goes into every processor's private force vector. Software can also set and clear bits in each force vector directly.

For each processor, the controller merges the pending vector with that processor's force vector and then filters the result through the processor's mask. The surviving lines are split into two groups according to a programmable level-select vector. The high group always wins over the low group. Within the winning group, the highest-numbered line is presented to the processor as a registered 4-bit code.

When a processor acknowledges a line number, that line is removed from the shared pending vector and from that processor's force vector. Software reaches all state through a 32-bit register port with word offsets. Only the low eight address bits are decoded.

Top module: `prio_irq_ctrl`

## Requirements
- R1: Register word offsets are: level select 0x00, pending 0x04, processor-0 force alias 0x08, clear 0x0C, status 0x10, broadcast 0x14, mask of processor n at 0x40+4n, force of processor n at 0x80+4n. Read data carries the register in bits 15:1, and bits 31:16 read as zero.
- R2: Bit 0 never holds an interrupt. Every write stores only bits 15:1 of the written data, and bit 0 always reads back as zero.
- R3: The active set of a processor is (pending OR its force) AND its mask. Its request output gives the number of the highest active line in the selected group, with 0 meaning no request. The output is registered, so it reflects the state one clock earlier.
- R4: Active lines whose level-select bit is 1 form the high group. When the high group is non-empty, only the high group is considered. Otherwise the low group is considered.
- R5: A write to a per-processor force register sets the bits given in data bits 15:1 and clears the bits given in data bits 31:17: new = (old OR set) AND NOT clear, so clear wins when both are given. A write to 0x08 replaces processor 0's force vector with data bits 15:1.
- R6: Writes to the pending register have no effect. A write to the clear register removes every pending bit written as 1 in data bits 15:1.
- R7: The clear and status registers always read as zero, and writes to the status register change nothing.
- R8: A request line is sampled on the clock and counts only on a 0-to-1 transition. The new request goes to the force vector of every processor if the line's broadcast bit is 1, and to the pending vector otherwise.
- R9: An acknowledge from processor n with a 4-bit line number clears that bit in the pending vector and in processor n's force vector only.
- R10: When a new request and an acknowledge or a clear-register write hit the same bit in the same cycle, the bit ends up set.
- R11: Offsets not listed in R1, offsets that are not a multiple of 4, and mask or force offsets of processors at or above the configured count all read as zero, and writes to them change nothing.
- R12: An active reset clears every register, the edge history and all request outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write strobe for the register port |
| addr_i | input | 8 | Byte offset of the register |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i (combinational) |
| irq_i | input | 16 | Request lines; bit 0 is unused |
| ack_i | input | N_CPU | Acknowledge strobe, one per processor |
| ack_line_i | input | 4*N_CPU | Acknowledged line number, 4 bits per processor |
| irq_lvl_o | output | 4*N_CPU | Registered request code, 4 bits per processor |

## Verification
The hardest situation to reach is a single cycle in which several sources act on the same bit at once: a new edge on a line arrives together with an acknowledge or a clear write for that line, while a set/clear force write also touches it. Purely random stimulus rarely lines up a rising edge with an acknowledge of the same line. For that reason, the bench steers acknowledges towards the line each processor is currently being offered, and it also plays directed sequences that place a fresh edge in the same cycle as a clear write. Broadcast-then-acknowledge sequences on one processor confirm that the other processor's force copy survives.

// File: rtl/prio_irq_pkg.sv
package prio_irq_pkg;
  localparam int NUM_LINES = 16;
  localparam int CODE_W    = 4;

  typedef logic [NUM_LINES-1:0] vec_t;

  localparam vec_t LINE_MASK = 16'hFFFE;

  // word offsets (byte offset / 4)
  localparam logic [5:0] W_LEVEL = 6'd0;
  localparam logic [5:0] W_PEND  = 6'd1;
  localparam logic [5:0] W_ALIAS = 6'd2;
  localparam logic [5:0] W_CLR   = 6'd3;
  localparam logic [5:0] W_STAT  = 6'd4;
  localparam logic [5:0] W_BCAST = 6'd5;
  localparam logic [1:0] RG_MASK  = 2'd1;
  localparam logic [1:0] RG_FORCE = 2'd2;

  function automatic logic [CODE_W-1:0] top_line(vec_t v);
    logic [CODE_W-1:0] r;
    r = '0;
    for (int i = 1; i < NUM_LINES; i++) begin
      if (v[i]) r = CODE_W'(i);
    end
    return r;
  endfunction
endpackage

// File: rtl/prio_irq_edge.sv
module prio_irq_edge
  import prio_irq_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  vec_t irq_i,
  output vec_t rise_o
);
  vec_t irq_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= '0;
    else         irq_q <= irq_i;
  end

  assign rise_o = irq_i & ~irq_q & LINE_MASK;

  AST_RISE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|rise_o) |=> ((rise_o & $past(rise_o)) == '0)); // R8
endmodule

// File: rtl/prio_irq_regs.sv
module prio_irq_regs
  import prio_irq_pkg::*;
#(
  parameter int N_CPU = 2
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    wr_en_i,
  input  logic [7:0]              addr_i,
  input  logic [31:0]             wdata_i,
  output logic [31:0]             rdata_o,
  input  vec_t                    rise_i,
  input  logic [N_CPU-1:0]        ack_i,
  input  logic [CODE_W*N_CPU-1:0] ack_line_i,
  output vec_t                    level_o,
  output vec_t                    pend_o,
  output logic [NUM_LINES*N_CPU-1:0] mask_o,
  output logic [NUM_LINES*N_CPU-1:0] force_o
);
  logic       aligned;
  logic [5:0] word;
  logic [1:0] region;
  logic [3:0] slot;
  assign aligned = (addr_i[1:0] == 2'b00);
  assign word    = addr_i[7:2];
  assign region  = word[5:4];
  assign slot    = word[3:0];

  vec_t wset, wclr;
  assign wset = wdata_i[15:0] & LINE_MASK;
  assign wclr = wdata_i[31:16] & LINE_MASK;

  logic wr_ok, wr_level, wr_alias, wr_clr, wr_bcast;
  assign wr_ok    = wr_en_i && aligned;
  assign wr_level = wr_ok && (word == W_LEVEL);
  assign wr_alias = wr_ok && (word == W_ALIAS);
  assign wr_clr   = wr_ok && (word == W_CLR);
  assign wr_bcast = wr_ok && (word == W_BCAST);

  vec_t level_q, pend_q, bcast_q, pend_d;
  vec_t mask_q  [N_CPU];
  vec_t force_q [N_CPU];

  vec_t ack_all, bc_rise, loc_rise;
  always_comb begin
    ack_all = '0;
    for (int c = 0; c < N_CPU; c++) begin
      if (ack_i[c]) ack_all[ack_line_i[CODE_W*c +: CODE_W]] = 1'b1;
    end
  end
  assign bc_rise  = rise_i & bcast_q;
  assign loc_rise = rise_i & ~bcast_q;

  // clears first, new requests last so they win
  assign pend_d = (pend_q & ~(wr_clr ? wset : '0) & ~ack_all) | loc_rise;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      level_q <= '0;
      pend_q  <= '0;
      bcast_q <= '0;
    end else begin
      pend_q <= pend_d;
      if (wr_level) level_q <= wset;
      if (wr_bcast) bcast_q <= wset;
    end
  end

  for (genvar c = 0; c < N_CPU; c++) begin : g_cpu
    logic hit_mask, hit_force;
    vec_t force_d;
    assign hit_mask  = wr_ok && (region == RG_MASK)  && (slot == 4'(c));
    assign hit_force = wr_ok && (region == RG_FORCE) && (slot == 4'(c));

    always_comb begin
      force_d = force_q[c];
      if (hit_force) force_d = (force_d | wset) & ~wclr;
      if ((c == 0) && wr_alias) force_d = wset;
      if (ack_i[c]) force_d[ack_line_i[CODE_W*c +: CODE_W]] = 1'b0;
      force_d = force_d | bc_rise;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        mask_q[c]  <= '0;
        force_q[c] <= '0;
      end else begin
        force_q[c] <= force_d;
        if (hit_mask) mask_q[c] <= wset;
      end
    end

    assign mask_o[NUM_LINES*c +: NUM_LINES]  = mask_q[c];
    assign force_o[NUM_LINES*c +: NUM_LINES] = force_q[c];

    AST_BCAST_ALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (|bc_rise) |=> ((force_q[c] & $past(bc_rise)) == $past(bc_rise))); // R8

    AST_ACK_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ack_i[c] && !rise_i[ack_line_i[CODE_W*c +: CODE_W]])
      |=> (!pend_q[$past(ack_line_i[CODE_W*c +: CODE_W])] &&
           !force_q[c][$past(ack_line_i[CODE_W*c +: CODE_W])])); // R9
  end

  always_comb begin
    rdata_o = '0;
    if (aligned) begin
      case (word)
        W_LEVEL: rdata_o[15:0] = level_q;
        W_PEND:  rdata_o[15:0] = pend_q;
        W_ALIAS: rdata_o[15:0] = force_q[0];
        W_BCAST: rdata_o[15:0] = bcast_q;
        default: rdata_o = '0;
      endcase
      for (int c = 0; c < N_CPU; c++) begin
        if ((region == RG_MASK)  && (slot == 4'(c))) rdata_o[15:0] = mask_q[c];
        if ((region == RG_FORCE) && (slot == 4'(c))) rdata_o[15:0] = force_q[c];
      end
    end
  end

  assign level_o = level_q;
  assign pend_o  = pend_q;

  AST_CLR_WORKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_clr |=> ((pend_q & $past(wset & ~rise_i)) == '0)); // R6

  AST_PEND_RO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && (addr_i == 8'h04) && (rise_i == '0) && (ack_i == '0))
    |=> (pend_q == $past(pend_q))); // R6

  AST_NEW_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|loc_rise) |=> ((pend_q & $past(loc_rise)) == $past(loc_rise))); // R10
endmodule

// File: rtl/prio_irq_sel.sv
module prio_irq_sel
  import prio_irq_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  vec_t              pend_i,
  input  vec_t              force_i,
  input  vec_t              mask_i,
  input  vec_t              level_i,
  output logic [CODE_W-1:0] req_o
);
  vec_t act, hi_grp, lo_grp;
  assign act    = (pend_i | force_i) & mask_i;
  assign hi_grp = act & level_i;
  assign lo_grp = act & ~level_i;

  logic [CODE_W-1:0] req_d;
  assign req_d = (|hi_grp) ? top_line(hi_grp) : top_line(lo_grp);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) req_o <= '0;
    else         req_o <= req_d;
  end

  AST_REQ_ACTIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_o != '0) |-> ((($past(act) >> req_o) & 16'd1) == 16'd1)); // R3

  AST_HIGH_FIRST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|hi_grp) |=> ((req_o != '0) &&
                   ((($past(level_i) >> req_o) & 16'd1) == 16'd1))); // R4
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import prio_irq_pkg::*;
#(
  parameter int N_CPU = 2
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    wr_en_i,
  input  logic [7:0]              addr_i,
  input  logic [31:0]             wdata_i,
  output logic [31:0]             rdata_o,
  input  logic [15:0]             irq_i,
  input  logic [N_CPU-1:0]        ack_i,
  input  logic [4*N_CPU-1:0]      ack_line_i,
  output logic [4*N_CPU-1:0]      irq_lvl_o
);
  vec_t rise, level, pend;
  logic [NUM_LINES*N_CPU-1:0] mask_all, force_all;

  prio_irq_edge u_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .irq_i  (irq_i),
    .rise_o (rise)
  );

  prio_irq_regs #(.N_CPU(N_CPU)) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_en_i    (wr_en_i),
    .addr_i     (addr_i),
    .wdata_i    (wdata_i),
    .rdata_o    (rdata_o),
    .rise_i     (rise),
    .ack_i      (ack_i),
    .ack_line_i (ack_line_i),
    .level_o    (level),
    .pend_o     (pend),
    .mask_o     (mask_all),
    .force_o    (force_all)
  );

  for (genvar c = 0; c < N_CPU; c++) begin : g_sel
    prio_irq_sel u_sel (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .pend_i  (pend),
      .force_i (force_all[NUM_LINES*c +: NUM_LINES]),
      .mask_i  (mask_all[NUM_LINES*c +: NUM_LINES]),
      .level_i (level),
      .req_o   (irq_lvl_o[CODE_W*c +: CODE_W])
    );
  end
endmodule

// File: tb/prio_irq_ctrl_tb_top.sv
module prio_irq_ctrl_tb_top;
  localparam int NC = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic          we = 1'b0;
  logic [7:0]    addr = '0;
  logic [31:0]   wdata = '0;
  logic [31:0]   rdata;
  logic [15:0]   irq = '0;
  logic [NC-1:0] ack = '0;
  logic [4*NC-1:0] ackl = '0;
  logic [4*NC-1:0] lvl;

  prio_irq_ctrl #(.N_CPU(NC)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(we), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .irq_i(irq), .ack_i(ack), .ack_line_i(ackl), .irq_lvl_o(lvl)
  );

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [15:0] m_level = '0, m_pend = '0, m_bcast = '0, m_irqq = '0;
  logic [15:0] m_mask [NC];
  logic [15:0] m_force [NC];

  function automatic logic [3:0] hi_bit(logic [15:0] v);
    for (int i = 15; i >= 1; i--) if (v[i]) return 4'(i);
    return 4'd0;
  endfunction

  function automatic logic [3:0] exp_req(int c);
    logic [15:0] a;
    a = (m_pend | m_force[c]) & m_mask[c];
    if ((a & m_level) != 0) return hi_bit(a & m_level);
    return hi_bit(a);
  endfunction

  function automatic logic [31:0] exp_read(logic [7:0] a);
    if (a[1:0] != 0) return 0;
    case (a)
      8'h00: return {16'd0, m_level};
      8'h04: return {16'd0, m_pend};
      8'h08: return {16'd0, m_force[0]};
      8'h14: return {16'd0, m_bcast};
      default: ;
    endcase
    for (int c = 0; c < NC; c++) begin
      if (a == 8'(8'h40 + 4*c)) return {16'd0, m_mask[c]};
      if (a == 8'(8'h80 + 4*c)) return {16'd0, m_force[c]};
    end
    return 0;
  endfunction

  function automatic string tag(logic [7:0] a);
    case (a)
      8'h00, 8'h14: return "R1/R2";
      8'h04: return "R6/R8/R9/R10";
      8'h0C, 8'h10: return "R7";
      8'h08, 8'h80, 8'h84: return "R5/R8/R9";
      8'h40, 8'h44: return "R1/R2";
      default: return "R11";
    endcase
  endfunction

  task automatic check(string r, logic [31:0] act, logic [31:0] exp, string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", r, what, act, exp);
    end
  endtask

  task automatic model_step();
    logic [15:0] rise, set, clr, ackv, f;
    rise = irq & ~m_irqq & 16'hFFFE;
    set  = wdata[15:0] & 16'hFFFE;
    clr  = wdata[31:16] & 16'hFFFE;
    ackv = '0;
    for (int c = 0; c < NC; c++) if (ack[c]) ackv[ackl[4*c +: 4]] = 1'b1;
    for (int c = 0; c < NC; c++) begin
      f = m_force[c];
      if (we && addr == 8'(8'h80 + 4*c)) f = (f | set) & ~clr;
      if (we && addr == 8'h08 && c == 0) f = set;
      if (ack[c]) f[ackl[4*c +: 4]] = 1'b0;
      m_force[c] = f | (rise & m_bcast);
      if (we && addr == 8'(8'h40 + 4*c)) m_mask[c] = set;
    end
    m_pend = m_pend & ~ackv;
    if (we && addr == 8'h0C) m_pend = m_pend & ~set;
    m_pend = m_pend | (rise & ~m_bcast);
    if (we && addr == 8'h00) m_level = set;
    if (we && addr == 8'h14) m_bcast = set;
    m_irqq = irq;
  endtask

  task automatic cyc(logic w, logic [7:0] a, logic [31:0] d, logic [15:0] ir,
                     logic [NC-1:0] ak, logic [4*NC-1:0] akl);
    logic [3:0] e [NC];
    @(negedge clk);
    we = w; addr = a; wdata = d; irq = ir; ack = ak; ackl = akl;
    #1;
    check(tag(a), rdata, exp_read(a), $sformatf("read @%h", a));
    for (int c = 0; c < NC; c++) e[c] = exp_req(c);
    model_step();
    @(posedge clk);
    #1;
    for (int c = 0; c < NC; c++)
      check("R3/R4", 32'(lvl[4*c +: 4]), 32'(e[c]), $sformatf("request cpu%0d", c));
  endtask

  task automatic model_reset();
    m_level = '0; m_pend = '0; m_bcast = '0; m_irqq = '0;
    for (int c = 0; c < NC; c++) begin m_mask[c] = '0; m_force[c] = '0; end
  endtask

  logic [7:0] addr_pool [14] = '{8'h00, 8'h04, 8'h08, 8'h0C, 8'h10, 8'h14, 8'h40,
                                 8'h44, 8'h48, 8'h80, 8'h84, 8'h88, 8'hC0, 8'h41};

  initial begin
    #(4 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] ir;
    logic [NC-1:0] ak;
    logic [4*NC-1:0] akl;
    void'($urandom(32'd4021));
    model_reset();
    repeat (3) @(posedge clk);
    #1;
    check("R12", 32'(lvl), 0, "request in reset");
    @(negedge clk) rst_n = 1'b1;

    // R12: all registers zero after reset
    cyc(0, 8'h00, 0, 0, 0, 0);
    cyc(0, 8'h04, 0, 0, 0, 0);
    cyc(0, 8'h40, 0, 0, 0, 0);
    cyc(0, 8'h80, 0, 0, 0, 0);

    // directed: unmask all, lines 3 and 9 arrive
    cyc(1, 8'h40, 32'hFFFF_FFFF, 0, 0, 0);
    cyc(1, 8'h44, 32'hFFFF_FFFF, 0, 0, 0);
    cyc(0, 8'h40, 0, 16'h0208, 0, 0);
    cyc(0, 8'h04, 0, 16'h0208, 0, 0);
    cyc(1, 8'h00, 32'h0000_0009, 16'h0208, 0, 0);  // R4: line 3 high, bit0 dropped R2
    cyc(0, 8'h00, 0, 16'h0208, 0, 0);
    cyc(1, 8'h04, 32'hFFFF, 16'h0208, 0, 0);       // R6 pending read-only
    cyc(1, 8'h10, 32'hFFFF, 16'h0208, 0, 0);       // R7 status ignored
    cyc(0, 8'h04, 0, 16'h0208, 2'b01, 8'h03);      // R9 ack line 3 cpu0
    cyc(0, 8'h04, 0, 16'h0000, 0, 0);
    cyc(1, 8'h0C, 32'h0000_0200, 16'h0200, 0, 0);  // R10 clear + new edge on 9
    cyc(0, 8'h04, 0, 16'h0200, 0, 0);
    cyc(1, 8'h14, 32'h0000_0020, 16'h0000, 0, 0);  // R8 broadcast line 5
    cyc(0, 8'h80, 0, 16'h0020, 0, 0);
    cyc(0, 8'h84, 0, 16'h0020, 2'b01, 8'h05);      // R9 ack cpu0 only
    cyc(0, 8'h84, 0, 16'h0020, 0, 0);
    cyc(0, 8'h80, 0, 16'h0020, 0, 0);
    cyc(1, 8'h84, 32'h0004_0044, 0, 0, 0);         // R5 set 2,6 clear 2
    cyc(0, 8'h84, 0, 0, 0, 0);
    cyc(1, 8'h08, 32'h0000_8001, 0, 0, 0);         // R5 alias replace
    cyc(0, 8'h80, 0, 0, 0, 0);
    cyc(1, 8'h48, 32'hFFFF_FFFF, 0, 0, 0);         // R11 cpu beyond count
    cyc(1, 8'h88, 32'hFFFF_FFFF, 0, 0, 0);
    cyc(1, 8'h41, 32'h0, 0, 0, 0);                 // R11 unaligned
    cyc(0, 8'h40, 0, 0, 0, 0);
    cyc(0, 8'h0C, 0, 0, 0, 0);

    // random phase
    ir = 16'h0;
    for (int n = 0; n < 4000; n++) begin
      ir = ir ^ 16'($urandom & $urandom & $urandom);
      ak = '0;
      akl = '0;
      for (int c = 0; c < NC; c++) begin
        if ($urandom % 4 == 0) begin
          ak[c] = 1'b1;
          akl[4*c +: 4] = ($urandom % 3 != 0) ? exp_req(c) : 4'($urandom);
        end
      end
      cyc(($urandom % 3) == 0, addr_pool[$urandom % 14],
          ($urandom % 4 == 0) ? ($urandom & 32'hFFFF) : $urandom, ir, ak, akl);
    end

    // R12: reset in mid-run clears state
    @(negedge clk);
    we = 0; addr = 8'h04; irq = '0; ack = '0;
    rst_n = 1'b0;
    model_reset();
    #1;
    check("R12", 32'(lvl), 0, "request after reset");
    check("R12", rdata, 0, "pending after reset");
    @(negedge clk) rst_n = 1'b1;
    cyc(0, 8'h80, 0, 0, 0, 0);
    cyc(0, 8'h14, 0, 0, 0, 0);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule